// File: doc/BRIEF.md
# Twin 32-bit Interval Timer

This block holds two independent 32-bit up-counters, a low half and a high half, reached through a plain single-cycle register port. The port has an address, a write strobe, write data and read data. Reads are combinational from the address. Each half has a writable counter, a period register and a 2-bit run-mode field. The run-mode fields sit in a shared control word. A global word selects the timer mode and releases each half from reset.

A half counts one step per clock while it is running. When its count equals its period, the half pulses its interrupt for one clock and wraps to zero. In run-once mode the half then clears its own mode field and stops. In repeat mode it keeps going.

An optional compare register watches the low counter. A driver that wants single events from a free-running low half writes the current count plus a delta into the compare register. The event output pulses when the low counter steps onto that value.

Top module: `twin_interval_timer`

## Requirements
- R1: After reset, both counters, the control word, the global word and the compare register read 0, and both period registers read 0xFFFFFFFF. All three interrupt outputs are low.
- R2: The registers decode at these offsets: low counter 0x10, high counter 0x14, low period 0x18, high period 0x1C, control 0x20, global 0x24 and compare 0x28. Only bits 7:6 and 23:22 of the control word are stored. Only bits 3:0 of the global word are stored. Every other bit, and every unmapped address, reads 0.
- R3: A register write takes effect at the next rising clock edge. A write to a counter overrides counting in that cycle.
- R4: A half runs only when all three of these hold: global bits 3:2 equal 01 (dual unchained); its release bit (global bit 0 for low, bit 1 for high) is 1; its mode field is 01 or 10. Otherwise its counter holds and its interrupt stays low.
- R5: A running half whose count differs from its period increments by exactly one per clock.
- R6: A running half whose count equals its period wraps to 0 at the next edge. Its interrupt (irq_lo or irq_hi) is high for that one following clock.
- R7: At such a wrap, a half in mode 01 (run once) clears its mode field to 00. In mode 10 (repeat) the field stays. A control write in the same cycle wins.
- R8: irq_cmp pulses for one clock after an edge at which the low half stepped (incremented or wrapped) onto a value equal to the compare register.
- R9: Writing 0 to the control word stops both halves, and both counters hold their values.
- R10: Mode 11 is treated as not running. The counter holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Register byte offset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for addr, combinational |
| irq_lo | output | 1 | Low-half wrap interrupt, one-clock pulse |
| irq_hi | output | 1 | High-half wrap interrupt, one-clock pulse |
| irq_cmp | output | 1 | Compare-match event, one-clock pulse |

## Verification
The bench builds the block with its defaults: 32-bit data, an 8-bit address, the compare unit present and decoded at 0x28. Because the width is full 32, a counter preload near 0xFFFFFFFF together with a period of 0xFFFFFFFF brings the natural wrap at the top of the range within a few cycles. It also brings a compare match just below it. With the compare unit present, the event path can be cross-checked against the low half's stepping. This covers wrap and stepping in both continuous and run-once modes, as well as a period of zero.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    EN_OFF  = 2'b00,
    EN_ONCE = 2'b01,
    EN_CONT = 2'b10,
    EN_RSVD = 2'b11
  } en_mode_e;

  localparam int NUM_HALF = 2;
  localparam logic [1:0] TMODE_DUAL = 2'b01;
  localparam int GLB_W = 4;
  localparam int GLB_TMODE_LSB = 2;

  function automatic int mode_lsb(input int h);
    return (h == 0) ? 6 : 22;
  endfunction

endpackage

// File: rtl/tmr_half.sv
module tmr_half
  import tmr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         released,
  input  logic         tmode_ok,
  input  logic         mode_we,
  input  logic [1:0]   mode_wdata,
  input  logic         cnt_we,
  input  logic         per_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt,
  output logic [W-1:0] per,
  output en_mode_e     mode,
  output logic         irq,
  output logic         adv,
  output logic [W-1:0] cnt_nxt
);

  logic run;
  logic hit;

  always_comb begin
    run     = released && tmode_ok && ((mode == EN_ONCE) || (mode == EN_CONT));
    hit     = (cnt == per);
    cnt_nxt = hit ? '0 : cnt + W'(1);
    adv     = run && !cnt_we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      per  <= '1;
      mode <= EN_OFF;
      irq  <= 1'b0;
    end else begin
      irq <= adv && hit;
      if (cnt_we)   cnt <= wdata;
      else if (adv) cnt <= cnt_nxt;
      if (per_we)   per <= wdata;
      if (mode_we)                               mode <= en_mode_e'(mode_wdata);
      else if (adv && hit && (mode == EN_ONCE))  mode <= EN_OFF;
    end
  end

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_we) |=> $stable(cnt));  // R4

  AST_NO_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !irq);  // R4

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cnt_we && !hit) |=> (cnt == $past(cnt) + W'(1)) && !irq);  // R5

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cnt_we && hit) |=> (cnt == '0) && irq);  // R6

  AST_ONCE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cnt_we && hit && (mode == EN_ONCE) && !mode_we) |=> (mode == EN_OFF));  // R7

endmodule

// File: rtl/tmr_cmp.sv
module tmr_cmp #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmp_we,
  input  logic [W-1:0] wdata,
  input  logic         lo_adv,
  input  logic [W-1:0] lo_nxt,
  output logic [W-1:0] cmp_val,
  output logic         evt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_val <= '0;
      evt     <= 1'b0;
    end else begin
      evt <= lo_adv && (lo_nxt == cmp_val);
      if (cmp_we) cmp_val <= wdata;
    end
  end

  AST_EVT_NEEDS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !lo_adv |=> !evt);  // R8

endmodule

// File: rtl/tmr_rdmux.sv
module tmr_rdmux #(
  parameter int W = 32,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFF_CNT_LO = 'h10,
  parameter logic [ADDR_W-1:0] OFF_CNT_HI = 'h14,
  parameter logic [ADDR_W-1:0] OFF_PER_LO = 'h18,
  parameter logic [ADDR_W-1:0] OFF_PER_HI = 'h1C,
  parameter logic [ADDR_W-1:0] OFF_CTL    = 'h20,
  parameter logic [ADDR_W-1:0] OFF_GLB    = 'h24,
  parameter logic [ADDR_W-1:0] OFF_CMP    = 'h28,
  parameter bit CMP_EN = 1'b1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      cnt_lo,
  input  logic [W-1:0]      cnt_hi,
  input  logic [W-1:0]      per_lo,
  input  logic [W-1:0]      per_hi,
  input  logic [W-1:0]      ctl_word,
  input  logic [W-1:0]      glb_word,
  input  logic [W-1:0]      cmp_val,
  output logic [W-1:0]      rd_data
);

  always_comb begin
    if      (addr == OFF_CNT_LO)          rd_data = cnt_lo;
    else if (addr == OFF_CNT_HI)          rd_data = cnt_hi;
    else if (addr == OFF_PER_LO)          rd_data = per_lo;
    else if (addr == OFF_PER_HI)          rd_data = per_hi;
    else if (addr == OFF_CTL)             rd_data = ctl_word;
    else if (addr == OFF_GLB)             rd_data = glb_word;
    else if (CMP_EN && addr == OFF_CMP)   rd_data = cmp_val;
    else                                  rd_data = '0;
  end

endmodule

// File: rtl/twin_interval_timer.sv
module twin_interval_timer
  import tmr_pkg::*;
#(
  parameter int W = 32,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFF_CNT_LO = 'h10,
  parameter logic [ADDR_W-1:0] OFF_CNT_HI = 'h14,
  parameter logic [ADDR_W-1:0] OFF_PER_LO = 'h18,
  parameter logic [ADDR_W-1:0] OFF_PER_HI = 'h1C,
  parameter logic [ADDR_W-1:0] OFF_CTL    = 'h20,
  parameter logic [ADDR_W-1:0] OFF_GLB    = 'h24,
  parameter logic [ADDR_W-1:0] OFF_CMP    = 'h28,
  parameter bit CMP_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [W-1:0]      wr_data,
  output logic [W-1:0]      rd_data,
  output logic              irq_lo,
  output logic              irq_hi,
  output logic              irq_cmp
);

  logic [GLB_W-1:0] glb_q;
  logic             tmode_ok;
  logic             ctl_we;
  logic             glb_we;
  logic             cmp_we;

  logic [W-1:0] cnt_q   [NUM_HALF];
  logic [W-1:0] per_q   [NUM_HALF];
  en_mode_e     mode_q  [NUM_HALF];
  logic         irq_q   [NUM_HALF];
  logic         adv     [NUM_HALF];
  logic [W-1:0] cnt_nxt [NUM_HALF];

  logic [W-1:0] ctl_word;
  logic [W-1:0] glb_word;
  logic [W-1:0] cmp_val;

  assign ctl_we   = wr_en && (addr == OFF_CTL);
  assign glb_we   = wr_en && (addr == OFF_GLB);
  assign cmp_we   = wr_en && (addr == OFF_CMP);
  assign tmode_ok = (glb_q[GLB_TMODE_LSB +: 2] == TMODE_DUAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      glb_q <= '0;
    else if (glb_we) glb_q <= wr_data[GLB_W-1:0];
  end

  for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
    localparam int LSB = mode_lsb(h);
    localparam logic [ADDR_W-1:0] A_CNT = (h == 0) ? OFF_CNT_LO : OFF_CNT_HI;
    localparam logic [ADDR_W-1:0] A_PER = (h == 0) ? OFF_PER_LO : OFF_PER_HI;

    tmr_half #(.W(W)) u_half (
      .clk        (clk),
      .rst_n      (rst_n),
      .released   (glb_q[h]),
      .tmode_ok   (tmode_ok),
      .mode_we    (ctl_we),
      .mode_wdata (wr_data[LSB +: 2]),
      .cnt_we     (wr_en && (addr == A_CNT)),
      .per_we     (wr_en && (addr == A_PER)),
      .wdata      (wr_data),
      .cnt        (cnt_q[h]),
      .per        (per_q[h]),
      .mode       (mode_q[h]),
      .irq        (irq_q[h]),
      .adv        (adv[h]),
      .cnt_nxt    (cnt_nxt[h])
    );
  end

  always_comb begin
    ctl_word = '0;
    for (int h = 0; h < NUM_HALF; h++) begin
      ctl_word[mode_lsb(h) +: 2] = mode_q[h];
    end
    glb_word = '0;
    glb_word[GLB_W-1:0] = glb_q;
  end

  if (CMP_EN) begin : g_cmp
    tmr_cmp #(.W(W)) u_cmp (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmp_we  (cmp_we),
      .wdata   (wr_data),
      .lo_adv  (adv[0]),
      .lo_nxt  (cnt_nxt[0]),
      .cmp_val (cmp_val),
      .evt     (irq_cmp)
    );
  end else begin : g_nocmp
    assign cmp_val = '0;
    assign irq_cmp = 1'b0;
    logic unused_cmp_tap;
    assign unused_cmp_tap = ^{cmp_we, adv[0], cnt_nxt[0]};
  end

  logic unused_hi_tap;
  assign unused_hi_tap = ^{adv[1], cnt_nxt[1]};

  tmr_rdmux #(
    .W(W), .ADDR_W(ADDR_W),
    .OFF_CNT_LO(OFF_CNT_LO), .OFF_CNT_HI(OFF_CNT_HI),
    .OFF_PER_LO(OFF_PER_LO), .OFF_PER_HI(OFF_PER_HI),
    .OFF_CTL(OFF_CTL), .OFF_GLB(OFF_GLB), .OFF_CMP(OFF_CMP),
    .CMP_EN(CMP_EN)
  ) u_rdmux (
    .addr     (addr),
    .cnt_lo   (cnt_q[0]),
    .cnt_hi   (cnt_q[1]),
    .per_lo   (per_q[0]),
    .per_hi   (per_q[1]),
    .ctl_word (ctl_word),
    .glb_word (glb_word),
    .cmp_val  (cmp_val),
    .rd_data  (rd_data)
  );

  assign irq_lo = irq_q[0];
  assign irq_hi = irq_q[1];

  AST_CMP_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_cmp && !$past(cmp_we)) |-> (cnt_q[0] == cmp_val));  // R8

  AST_CTL_ZERO_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && (wr_data == '0)) |=> (mode_q[0] == EN_OFF) && (mode_q[1] == EN_OFF));  // R9

endmodule

// File: tb/twin_interval_timer_tb.sv
module twin_interval_timer_tb;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq_lo, irq_hi, irq_cmp;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  twin_interval_timer u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .irq_lo(irq_lo), .irq_hi(irq_hi), .irq_cmp(irq_cmp)
  );

  // behavioural reference
  logic [31:0] m_cnt [2];
  logic [31:0] m_per [2];
  logic [1:0]  m_mode [2];
  logic [3:0]  m_glb;
  logic [31:0] m_cmp;
  logic        m_irq [2];
  logic        m_evt;
  logic        s_go, s_cw, s_mv, s_hit;
  logic [31:0] s_nx;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int h = 0; h < 2; h++) begin
        m_cnt[h] = 0; m_per[h] = 32'hFFFF_FFFF; m_mode[h] = 0; m_irq[h] = 0;
      end
      m_glb = 0; m_cmp = 0; m_evt = 0;
    end else begin
      for (int h = 0; h < 2; h++) begin
        s_go  = m_glb[h] && (m_glb[3:2] == 2'b01) && (m_mode[h] == 2'd1 || m_mode[h] == 2'd2);
        s_cw  = wr_en && (addr == ((h == 0) ? 8'h10 : 8'h14));
        s_mv  = s_go && !s_cw;
        s_hit = (m_cnt[h] == m_per[h]);
        s_nx  = s_hit ? 32'd0 : m_cnt[h] + 32'd1;
        m_irq[h] = s_mv && s_hit;
        if (h == 0) m_evt = s_mv && (s_nx == m_cmp);
        if (s_cw) m_cnt[h] = wr_data;
        else if (s_mv) m_cnt[h] = s_nx;
        if (wr_en && addr == ((h == 0) ? 8'h18 : 8'h1C)) m_per[h] = wr_data;
        if (wr_en && addr == 8'h20) m_mode[h] = (h == 0) ? wr_data[7:6] : wr_data[23:22];
        else if (s_mv && s_hit && m_mode[h] == 2'd1) m_mode[h] = 2'd0;
      end
      if (wr_en && addr == 8'h24) m_glb = wr_data[3:0];
      if (wr_en && addr == 8'h28) m_cmp = wr_data;
    end
  end

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h10: return m_cnt[0];
      8'h14: return m_cnt[1];
      8'h18: return m_per[0];
      8'h1C: return m_per[1];
      8'h20: return {8'd0, m_mode[1], 14'd0, m_mode[0], 6'd0};
      8'h24: return {28'd0, m_glb};
      8'h28: return m_cmp;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string rd_tag(input logic [7:0] a);
    case (a)
      8'h10, 8'h14: return "R5";
      8'h20:        return "R7";
      8'h28:        return "R8";
      default:      return "R2";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-clock comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(rd_tag(addr), rd_data, m_read(addr));
      chk("R6", {31'd0, irq_lo}, {31'd0, m_irq[0]});
      chk("R6", {31'd0, irq_hi}, {31'd0, m_irq[1]});
      chk("R8", {31'd0, irq_cmp}, {31'd0, m_evt});
    end
  end

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wr_en = 1'b1; wr_data = d;
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    addr = a;
    @(negedge clk);
    chk(tag, rd_data, exp);
    @(posedge clk);
    #2;
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset values
    rd_chk(8'h10, 32'h0, "R1");
    rd_chk(8'h14, 32'h0, "R1");
    rd_chk(8'h18, 32'hFFFF_FFFF, "R1");
    rd_chk(8'h1C, 32'hFFFF_FFFF, "R1");
    rd_chk(8'h20, 32'h0, "R1");
    rd_chk(8'h24, 32'h0, "R1");
    rd_chk(8'h28, 32'h0, "R1");
    rd_chk(8'h00, 32'h0, "R2");
    // R3 write lands next edge
    wr(8'h10, 32'h0000_1234);
    rd_chk(8'h10, 32'h0000_1234, "R3");
    // R2 field masking
    wr(8'h20, 32'hFFFF_FFFF);
    rd_chk(8'h20, 32'h00C0_00C0, "R2");
    // R4 timer mode not dual: hold
    wr(8'h20, 32'h0000_0080);
    wr(8'h24, 32'h0000_0003);
    step(4);
    rd_chk(8'h10, 32'h0000_1234, "R4");
    // R4 not released: hold
    wr(8'h24, 32'h0000_0004);
    step(3);
    rd_chk(8'h10, 32'h0000_1234, "R4");
    // R10 mode 11 holds
    wr(8'h20, 32'h0000_00C0);
    wr(8'h24, 32'h0000_0007);
    step(4);
    rd_chk(8'h10, 32'h0000_1234, "R10");
    // R9 control zero
    wr(8'h20, 32'h0);
    rd_chk(8'h20, 32'h0, "R9");
    // R5/R6/R7: low repeat, high run-once
    wr(8'h10, 32'h0);
    wr(8'h18, 32'd4);
    wr(8'h1C, 32'd2);
    wr(8'h20, 32'h0040_0080);
    step(30);
    rd_chk(8'h20, 32'h0000_0080, "R7");
    // R8 compare on a cycling low half
    wr(8'h28, 32'd3);
    step(20);
    // R4 low held in reset
    wr(8'h24, 32'h0000_0006);
    step(5);
    wr(8'h24, 32'h0000_0007);
    // R6/R8 at top of range
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h10, 32'hFFFF_FFF0);
    wr(8'h28, 32'hFFFF_FFFA);
    step(24);
    // R9 stop both with counters held
    wr(8'h20, 32'h0);
    step(5);
    // period zero: wrap every cycle
    wr(8'h10, 32'h0);
    wr(8'h18, 32'h0);
    wr(8'h20, 32'h0000_0080);
    step(6);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule